// File: doc/BRIEF.md
# UART Interrupt Source Combiner

This block gathers the interrupt causes of one serial channel into a single request line. The four causes are receive, error, transmit and modem. Each one is held in a sticky source-latch register. A mask register gates the latched causes into a pending view, and the request line is high whenever that view is nonzero. Software clears causes by writing ones, either through the pending path or through the source path.

Two causes are also raised from levels rather than from strobes. The transmit cause follows the transmit FIFO fill against a programmable threshold, and the receive cause follows the receive FIFO fill against a second threshold. A FIFO that is switched off makes the receive cause follow a plain data-ready flag instead. Both thresholds are a 3-bit field from the FIFO configuration word multiplied by a factor fixed per channel. The channel number is an elaboration-time parameter.

Top module: `uart_irq_combiner`

## Requirements
- R1: Cause bit positions are receive = 0, error = 1, transmit = 2, modem = 3; a high bit of `ev_set` sets the same bit of `src_pend` at the next clock edge, and a set bit stays set until it is cleared.
- R2: `pend` equals `src_pend` with the bits of `mask_q` removed, and `irq` is high exactly when `pend` is nonzero.
- R3: With the FIFO enabled (`fifo_cfg` bit 0 = 1), transmit threshold = `fifo_cfg[10:8]` × scale, and bit 2 of `src_pend` is set when `tx_count` is less than or equal to that threshold.
- R4: With the FIFO enabled, receive threshold = (`fifo_cfg[6:4]` + 1) × scale, and bit 0 of `src_pend` is set when `rx_count` is greater than or equal to it.
- R5: With the FIFO enabled, bit 0 of `src_pend` is also set when `rx_count` is nonzero and `rx_tmo_en` is low.
- R6: With the FIFO disabled, bit 0 of `src_pend` is set whenever `rx_ready` is high; the FIFO counts then set no cause.
- R7: The scale is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R8: A pending-clear write (`clr_pend_we`) clears the `clr_data` bits of the latched causes, so they leave both `src_pend` and `pend`.
- R9: A source-clear write (`clr_src_we`) clears the `clr_data` bits of `src_pend` only and leaves `mask_q` unchanged.
- R10: A cause raised in the same cycle as a clear of that bit wins: the bit is set after the edge.
- R11: A mask write loads `mask_data` into `mask_q` at the next edge; masked causes remain latched in `src_pend` and show in `pend` again once unmasked.
- R12: After reset `src_pend`, `mask_q` and `pend` are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_cfg | input | 11 | FIFO configuration: bit 0 enable, 6:4 receive threshold field, 10:8 transmit threshold field |
| rx_tmo_en | input | 1 | Receive timeout enable |
| rx_ready | input | 1 | Receive data ready (used when the FIFO is disabled) |
| tx_count | input | CW | Transmit FIFO fill |
| rx_count | input | CW | Receive FIFO fill |
| ev_set | input | 4 | Cause strobes, one bit per cause |
| clr_pend_we | input | 1 | Clear through the pending path |
| clr_src_we | input | 1 | Clear through the source path |
| clr_data | input | 4 | Bits to clear |
| mask_we | input | 1 | Mask load strobe |
| mask_data | input | 4 | New mask value |
| src_pend | output | 4 | Latched causes |
| mask_q | output | 4 | Current mask |
| pend | output | 4 | Unmasked latched causes |
| irq | output | 1 | Interrupt request |

## Verification
A cause that is being raised and a clear write of the same bit can land in one cycle. This happens both for explicit strobes and for threshold conditions that stay true. The bench drives a strobe on a bit and a source or pending clear of that bit in the same cycle, while clearing other bits. It then expects the raised bit still set and the other bits gone after the edge. A threshold that is still met while a clear is written is judged the same way: the bit must stay set.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int SRC_N   = 4;
   localparam int B_RX    = 0;
   localparam int B_ERR   = 1;
   localparam int B_TX    = 2;
   localparam int B_MDM   = 3;
   localparam int CFG_W   = 11;
   localparam int CFG_EN  = 0;
   localparam int RXLV_LO = 4;
   localparam int TXLV_LO = 8;
   localparam int LV_W    = 3;

   // threshold multiplier for a given channel number
   function automatic int unsigned chan_scale(input int unsigned ch);
      case (ch)
         0:       return 32;
         1, 4:    return 8;
         2, 3:    return 2;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/uirq_trigger.sv
module uirq_trigger
   import uirq_pkg::*;
#(
   parameter int unsigned CHANNEL = 0,
   parameter int          CW      = 8
) (
   input  logic [CFG_W-1:0] fifo_cfg,
   input  logic             rx_tmo_en,
   input  logic             rx_ready,
   input  logic [CW-1:0]    tx_count,
   input  logic [CW-1:0]    rx_count,
   output logic [SRC_N-1:0] trig
);
   localparam int unsigned SCALE = chan_scale(CHANNEL);
   localparam int          CMPW  = ((CW > 9) ? CW : 9) + 1;

   logic [CMPW-1:0] tx_lvl, rx_lvl, txc_w, rxc_w;
   logic            fifo_on;

   assign fifo_on = fifo_cfg[CFG_EN];
   assign txc_w   = CMPW'(tx_count);
   assign rxc_w   = CMPW'(rx_count);

   generate
      if (SCALE == 0) begin : g_noscale
         assign tx_lvl = '0;
         assign rx_lvl = '0;
      end else begin : g_scale
         assign tx_lvl = CMPW'(fifo_cfg[TXLV_LO +: LV_W]) * CMPW'(SCALE);
         assign rx_lvl = (CMPW'(fifo_cfg[RXLV_LO +: LV_W]) + CMPW'(1)) * CMPW'(SCALE);
      end
   endgenerate

   always_comb begin
      trig = '0;
      if (fifo_on) begin
         trig[B_TX] = (txc_w <= tx_lvl);
         trig[B_RX] = (rxc_w >= rx_lvl) || ((rx_count != '0) && !rx_tmo_en);
      end else begin
         trig[B_RX] = rx_ready;
      end
   end
endmodule

// File: rtl/uirq_src_bank.sv
module uirq_src_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] src_q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          src_q[i] <= 1'b0;
            else if (set_vec[i]) src_q[i] <= 1'b1;
            else if (clr_vec[i]) src_q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/uirq_gate.sv
module uirq_gate #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mask_we,
   input  logic [N-1:0] mask_data,
   input  logic [N-1:0] src_q,
   output logic [N-1:0] mask_q,
   output logic [N-1:0] pend,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_data;
   end

   assign pend = src_q & ~mask_q;
   assign irq  = |pend;
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
   import uirq_pkg::*;
#(
   parameter int unsigned CHANNEL = 0,
   parameter int          CW      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] fifo_cfg,
   input  logic             rx_tmo_en,
   input  logic             rx_ready,
   input  logic [CW-1:0]    tx_count,
   input  logic [CW-1:0]    rx_count,
   input  logic [SRC_N-1:0] ev_set,
   input  logic             clr_pend_we,
   input  logic             clr_src_we,
   input  logic [SRC_N-1:0] clr_data,
   input  logic             mask_we,
   input  logic [SRC_N-1:0] mask_data,
   output logic [SRC_N-1:0] src_pend,
   output logic [SRC_N-1:0] mask_q,
   output logic [SRC_N-1:0] pend,
   output logic             irq
);
   generate
      if (CW < 1 || CW > 16) begin : g_bad_cw
         $error("uart_irq_combiner: CW must lie in 1..16");
      end
   endgenerate

   logic [SRC_N-1:0] trig, set_vec, clr_vec;

   uirq_trigger #(.CHANNEL(CHANNEL), .CW(CW)) u_trig (
      .fifo_cfg (fifo_cfg),
      .rx_tmo_en(rx_tmo_en),
      .rx_ready (rx_ready),
      .tx_count (tx_count),
      .rx_count (rx_count),
      .trig     (trig)
   );

   assign set_vec = ev_set | trig;
   assign clr_vec = (clr_pend_we || clr_src_we) ? clr_data : '0;

   uirq_src_bank #(.N(SRC_N)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .src_q  (src_pend)
   );

   uirq_gate #(.N(SRC_N)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_we  (mask_we),
      .mask_data(mask_data),
      .src_q    (src_pend),
      .mask_q   (mask_q),
      .pend     (pend),
      .irq      (irq)
   );
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
   import uirq_pkg::*;
#(
   parameter int CW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] fifo_cfg,
   input logic             rx_tmo_en,
   input logic             rx_ready,
   input logic [CW-1:0]    rx_count,
   input logic [CW-1:0]    tx_count,
   input logic [SRC_N-1:0] ev_set,
   input logic             clr_pend_we,
   input logic             clr_src_we,
   input logic [SRC_N-1:0] clr_data,
   input logic             mask_we,
   input logic [SRC_N-1:0] mask_data,
   input logic [SRC_N-1:0] src_pend,
   input logic [SRC_N-1:0] mask_q,
   input logic             irq
);
   p_strobe_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set != '0) |=> ((src_pend & $past(ev_set)) == $past(ev_set)));

   p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_pend_we && !clr_src_we) |=> ((src_pend & $past(src_pend)) == $past(src_pend)));

   p_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_pend & ~mask_q) == '0) |-> !irq);

   p_tx_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_cfg[CFG_EN] && tx_count == '0) |=> src_pend[B_TX]);

   p_rx_notmo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_cfg[CFG_EN] && !rx_tmo_en && rx_count != '0) |=> src_pend[B_RX]);

   p_rx_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_cfg[CFG_EN] && rx_ready) |=> src_pend[B_RX]);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend_we && !fifo_cfg[CFG_EN] && !rx_ready)
      |=> ((src_pend & $past(clr_data & ~ev_set)) == '0));

   p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(mask_data)));

   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));
endmodule

bind uart_irq_combiner uirq_chk #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_cfg   (fifo_cfg),
   .rx_tmo_en  (rx_tmo_en),
   .rx_ready   (rx_ready),
   .rx_count   (rx_count),
   .tx_count   (tx_count),
   .ev_set     (ev_set),
   .clr_pend_we(clr_pend_we),
   .clr_src_we (clr_src_we),
   .clr_data   (clr_data),
   .mask_we    (mask_we),
   .mask_data  (mask_data),
   .src_pend   (src_pend),
   .mask_q     (mask_q),
   .irq        (irq)
);

// File: tb/sim_uart_irq_combiner.sv
module sim_uart_irq_combiner;
   localparam int CLK_PER = 10;
   localparam int CW      = 8;
   localparam int NVEC    = 10;

   // {en, txf[2:0], rxf[2:0], tmo, txc[7:0], rxc[7:0], rdy, expected src[3:0]}
   localparam logic [28:0] VEC [NVEC] = '{
      {1'b1, 3'd1, 3'd0, 1'b1, 8'd32,  8'd0,   1'b0, 4'b0100},
      {1'b1, 3'd1, 3'd0, 1'b1, 8'd33,  8'd31,  1'b0, 4'b0000},
      {1'b1, 3'd1, 3'd0, 1'b1, 8'd33,  8'd32,  1'b0, 4'b0001},
      {1'b1, 3'd1, 3'd0, 1'b0, 8'd33,  8'd1,   1'b0, 4'b0001},
      {1'b1, 3'd1, 3'd0, 1'b0, 8'd33,  8'd0,   1'b0, 4'b0000},
      {1'b0, 3'd7, 3'd0, 1'b0, 8'd0,   8'd200, 1'b0, 4'b0000},
      {1'b0, 3'd7, 3'd0, 1'b0, 8'd0,   8'd200, 1'b1, 4'b0001},
      {1'b1, 3'd0, 3'd7, 1'b1, 8'd0,   8'd255, 1'b1, 4'b0100},
      {1'b1, 3'd0, 3'd1, 1'b1, 8'd1,   8'd64,  1'b1, 4'b0001},
      {1'b1, 3'd7, 3'd1, 1'b1, 8'd224, 8'd63,  1'b0, 4'b0100}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [10:0]   fifo_cfg = '0;
   logic          rx_tmo_en = 1'b0, rx_ready = 1'b0;
   logic [CW-1:0] tx_count = '0, rx_count = '0;
   logic [3:0]    ev_set = '0, clr_data = '0, mask_data = '0;
   logic          clr_pend_we = 1'b0, clr_src_we = 1'b0, mask_we = 1'b0;
   logic [3:0]    src0, mask0, pend0, src1, mask1, pend1, src2, mask2, pend2;
   logic          irq0, irq1, irq2;
   int            n_chk = 0, n_bad = 0;
   bit            done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   uart_irq_combiner #(.CHANNEL(0), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_cfg(fifo_cfg), .rx_tmo_en(rx_tmo_en),
      .rx_ready(rx_ready), .tx_count(tx_count), .rx_count(rx_count), .ev_set(ev_set),
      .clr_pend_we(clr_pend_we), .clr_src_we(clr_src_we), .clr_data(clr_data),
      .mask_we(mask_we), .mask_data(mask_data),
      .src_pend(src0), .mask_q(mask0), .pend(pend0), .irq(irq0));

   uart_irq_combiner #(.CHANNEL(3), .CW(CW)) u1 (
      .clk(clk), .rst_n(rst_n), .fifo_cfg(fifo_cfg), .rx_tmo_en(rx_tmo_en),
      .rx_ready(rx_ready), .tx_count(tx_count), .rx_count(rx_count), .ev_set(ev_set),
      .clr_pend_we(clr_pend_we), .clr_src_we(clr_src_we), .clr_data(clr_data),
      .mask_we(mask_we), .mask_data(mask_data),
      .src_pend(src1), .mask_q(mask1), .pend(pend1), .irq(irq1));

   uart_irq_combiner #(.CHANNEL(7), .CW(CW)) u2 (
      .clk(clk), .rst_n(rst_n), .fifo_cfg(fifo_cfg), .rx_tmo_en(rx_tmo_en),
      .rx_ready(rx_ready), .tx_count(tx_count), .rx_count(rx_count), .ev_set(ev_set),
      .clr_pend_we(clr_pend_we), .clr_src_we(clr_src_we), .clr_data(clr_data),
      .mask_we(mask_we), .mask_data(mask_data),
      .src_pend(src2), .mask_q(mask2), .pend(pend2), .irq(irq2));

   function automatic logic [10:0] mk_cfg(input logic en, input logic [2:0] txf,
                                           input logic [2:0] rxf);
      return {txf, 1'b0, rxf, 3'b000, en};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock edge, inputs changed and outputs sampled on falling edges
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      fifo_cfg = '0; rx_ready = 1'b0; rx_tmo_en = 1'b0;
      tx_count = '0; rx_count = '0; ev_set = '0;
      clr_pend_we = 1'b0; clr_src_we = 1'b0; mask_we = 1'b0;
   endtask

   task automatic clear_all();
      idle_inputs();
      clr_src_we = 1'b1; clr_data = 4'hF;
      step();
      clr_src_we = 1'b0; clr_data = 4'h0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 src", {28'd0, src0}, 32'h0);
      chk("R12 mask", {28'd0, mask0}, 32'h0);
      chk("R12 pend", {28'd0, pend0}, 32'h0);
      chk("R12 irq", {31'd0, irq0}, 32'h0);
      rst_n = 1'b1;
      step();
      chk("R12 idle after release", {27'd0, irq0, src0}, 32'h0);

      // R3 R4 R5 R6 threshold table on channel 0 (scale 32)
      for (int i = 0; i < NVEC; i++) begin
         fifo_cfg  = mk_cfg(VEC[i][28], VEC[i][27:25], VEC[i][24:22]);
         rx_tmo_en = VEC[i][21];
         tx_count  = VEC[i][20:13];
         rx_count  = VEC[i][12:5];
         rx_ready  = VEC[i][4];
         step();
         chk($sformatf("R3/R4 R5 R6 vec%0d src", i), {28'd0, src0}, {28'd0, VEC[i][3:0]});
         chk($sformatf("R2 vec%0d irq", i), {31'd0, irq0}, {31'd0, (VEC[i][3:0] != 4'h0)});
         clear_all();
      end

      // R1 each strobe sets its own bit
      for (int b = 0; b < 4; b++) begin
         ev_set = 4'(1 << b);
         step();
         ev_set = '0;
         chk($sformatf("R1 bit%0d", b), {28'd0, src0}, 32'(1 << b));
         clear_all();
      end

      // R11 R2 masking
      ev_set = 4'hF; mask_we = 1'b1; mask_data = 4'b1010;
      step();
      ev_set = '0; mask_we = 1'b0;
      chk("R11 mask load", {28'd0, mask0}, 32'hA);
      chk("R2 pend", {28'd0, pend0}, 32'h5);
      chk("R2 irq", {31'd0, irq0}, 32'h1);
      mask_we = 1'b1; mask_data = 4'hF;
      step();
      mask_we = 1'b0;
      chk("R11 all masked irq", {31'd0, irq0}, 32'h0);
      chk("R11 src kept", {28'd0, src0}, 32'hF);

      // R8 pending clear
      clr_pend_we = 1'b1; clr_data = 4'b0001;
      step();
      clr_pend_we = 1'b0;
      chk("R8 src after pend clear", {28'd0, src0}, 32'hE);
      // R9 source clear leaves mask
      clr_src_we = 1'b1; clr_data = 4'b0100;
      step();
      clr_src_we = 1'b0;
      chk("R9 src", {28'd0, src0}, 32'hA);
      chk("R9 mask unchanged", {28'd0, mask0}, 32'hF);
      mask_we = 1'b1; mask_data = 4'h0;
      step();
      mask_we = 1'b0;
      chk("R11 unmask shows pend", {28'd0, pend0}, 32'hA);

      // R10 set beats clear in the same cycle, both clear paths
      clr_src_we = 1'b1; clr_data = 4'hF; ev_set = 4'b0010;
      step();
      clr_src_we = 1'b0; ev_set = '0;
      chk("R10 src clear vs strobe", {28'd0, src0}, 32'h2);
      clr_pend_we = 1'b1; clr_data = 4'hF; ev_set = 4'b1000;
      step();
      clr_pend_we = 1'b0; ev_set = '0;
      chk("R10 pend clear vs strobe", {28'd0, src0}, 32'h8);
      clear_all();
      fifo_cfg = mk_cfg(1'b0, 3'd0, 3'd0); rx_ready = 1'b1;
      clr_pend_we = 1'b1; clr_data = 4'hF;
      step();
      clr_pend_we = 1'b0;
      chk("R10 ready level vs clear", {28'd0, src0}, 32'h1);
      clear_all();

      // R7 channel scaling: u1 scale 2, u2 scale 0
      fifo_cfg = mk_cfg(1'b1, 3'd1, 3'd0); rx_tmo_en = 1'b1;
      tx_count = 8'd2; rx_count = 8'd1;
      step();
      chk("R7 ch3 tx at level", {28'd0, src1}, 32'h4);
      chk("R7 ch7 zero level", {28'd0, src2}, 32'h1);
      clear_all();
      fifo_cfg = mk_cfg(1'b1, 3'd1, 3'd0); rx_tmo_en = 1'b1;
      tx_count = 8'd3; rx_count = 8'd2;
      step();
      chk("R7 ch3 rx at level", {28'd0, src1}, 32'h1);
      chk("R7 ch7 tx above zero", {28'd0, src2}, 32'h1);
      clear_all();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule